// File: doc/BRIEF.md
# Dual-Size Signed Sequential Divider

This block is a multi-cycle signed integer divider with two operand sizes on one shared datapath. In byte mode it divides a 16-bit two's complement dividend by an 8-bit divisor. In word mode it divides a 32-bit dividend by a 16-bit divisor. The quotient and the remainder are packed into one result word as wide as the dividend, so the caller can write the whole result back into the register that held the dividend.

A caller pulses `start` with the size select and the operands. The divider takes the magnitudes of both operands and runs one restoring step per quotient bit. A final cycle then applies the signs and checks whether the quotient fits. `done` pulses for one cycle when the result and flags are ready. A zero divisor is caught at once and finishes with a flag. A quotient too large for its field also sets a flag. In both of these cases the stored result is left as it was.

Top module: `sdiv_dual`

## Requirements
- R1: Word mode (`wordMode`=1) treats `dividend[31:0]` and `divisor[15:0]` as signed. The quotient truncates toward zero and is placed in `result[15:0]`. The remainder takes the sign of the dividend and is placed in `result[31:16]`.
- R2: Byte mode (`wordMode`=0) uses only `dividend[15:0]` and `divisor[7:0]` as signed operands, and the upper input bits have no effect. The quotient goes to `result[7:0]`, the remainder (sign of the dividend) to `result[15:8]`, and `result[31:16]` is zero.
- R3: `start` is accepted on a rising edge while `busy` is low. For a nonzero divisor, `busy` is high from that edge for N+1 cycles, with N=16 in word mode and N=8 in byte mode. `done` is then high for exactly one cycle, beginning at the (N+1)th edge after the accepting edge. `done` and `busy` are never high together.
- R4: A zero divisor (all 16 bits in word mode, the low 8 bits in byte mode) makes `done` and `divZero` high in the cycle right after the accepting edge. In that case `overflow` is 0, `busy` stays low, and `result` keeps its previous value.
- R5: When the signed quotient lies outside the signed N-bit range, `overflow` is 1 when `done` rises and `result` keeps its previous value. The timing is the same as in R3. The quotient -2^(N-1) is in range and is not an overflow.
- R6: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own operands and its own timing.
- R7: `result`, `divZero` and `overflow` change only at the edge that raises `done`, and they hold until the next such edge. `divZero` and `overflow` are never both 1.
- R8: After reset, `busy`, `done`, `divZero` and `overflow` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division (taken only while idle) |
| wordMode | input | 1 | 1: 32/16 division, 0: 16/8 division |
| dividend | input | 32 | Signed dividend (low 16 bits in byte mode) |
| divisor | input | 16 | Signed divisor (low 8 bits in byte mode) |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed {remainder, quotient} |
| divZero | output | 1 | Last operation had a zero divisor |
| overflow | output | 1 | Last operation's quotient did not fit |

## Verification
Directed cases run all four sign combinations of dividend and divisor, so that errors in quotient sign and remainder sign show up separately. They also place the quotient exactly on the edges of the signed range, with both the most negative dividend and the most negative divisor, which separates correct overflow detection from an off-by-one. Byte-mode cases put junk in the unused upper input bits, including a divisor whose low byte is zero, to show which bits the block reads. Random cases, built from a chosen quotient, divisor and remainder or drawn fully at random, mix both sizes back to back. They also fire a second start in the middle of a run to confirm that it changes neither the result nor the cycle count.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef struct packed {
    logic load;     // capture operand magnitudes
    logic step;     // one restoring iteration
    logic fix;      // sign correction and write-back
    logic zeroEnd;  // finish on a zero divisor
  } sdivStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} sdivState_t;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl import sdiv_pkg::*; #(
  parameter int HALF_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wordMode,
  input  logic        dvsZero,
  output sdivStrobe_t strb,
  output logic        busy,
  output logic        done
);
  localparam int BH = HALF_W / 2;
  localparam int CW = $clog2(HALF_W + 1);

  sdivState_t state;
  logic [CW-1:0] cnt;

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (dvsZero) strb.zeroEnd = 1'b1;
          else         strb.load    = 1'b1;
        end
      end
      ST_RUN:  strb.step = 1'b1;
      ST_FIX:  strb.fix  = 1'b1;
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= strb.fix | strb.zeroEnd;
      unique case (state)
        ST_IDLE: begin
          if (strb.load) begin
            state <= ST_RUN;
            cnt   <= wordMode ? CW'(HALF_W - 1) : CW'(BH - 1);
          end
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_FIX;
          else           cnt   <= cnt - CW'(1);
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sdiv_dpath.sv
module sdiv_dpath import sdiv_pkg::*; #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sdivStrobe_t           strb,
  input  logic                  wordMode,
  input  logic [2*HALF_W-1:0]   dividend,
  input  logic [HALF_W-1:0]     divisor,
  output logic                  dvsZero,
  output logic [2*HALF_W-1:0]   result,
  output logic                  divZero,
  output logic                  overflow
);
  localparam int BH = HALF_W / 2;
  localparam int DW = 2 * HALF_W;

  // operand magnitudes, chosen by size
  logic              dvdNeg, dvsNeg;
  logic [DW-1:0]     wordDvdMag;
  logic [HALF_W-1:0] byteDvdMag;
  logic [HALF_W-1:0] remInit, quoInit, dvsMag;
  logic [BH-1:0]     byteDvsMag;

  always_comb begin
    wordDvdMag = dividend[DW-1] ? -dividend : dividend;
    byteDvdMag = dividend[HALF_W-1] ? -dividend[HALF_W-1:0] : dividend[HALF_W-1:0];
    byteDvsMag = divisor[BH-1] ? -divisor[BH-1:0] : divisor[BH-1:0];
    if (wordMode) begin
      dvdNeg  = dividend[DW-1];
      dvsNeg  = divisor[HALF_W-1];
      remInit = wordDvdMag[DW-1:HALF_W];
      quoInit = wordDvdMag[HALF_W-1:0];
      dvsMag  = divisor[HALF_W-1] ? -divisor : divisor;
      dvsZero = (divisor == '0);
    end else begin
      dvdNeg  = dividend[HALF_W-1];
      dvsNeg  = divisor[BH-1];
      remInit = {{BH{1'b0}}, byteDvdMag[HALF_W-1:BH]};
      quoInit = {byteDvdMag[BH-1:0], {BH{1'b0}}};
      dvsMag  = {{BH{1'b0}}, byteDvsMag};
      dvsZero = (divisor[BH-1:0] == '0);
    end
  end

  // iteration state
  logic [HALF_W-1:0] remR, quoR, dvsR;
  logic              negQ, negR, preOvf, modeR;

  logic [HALF_W:0]   trial, diff;
  logic              takeBit;

  always_comb begin
    trial   = {remR, quoR[HALF_W-1]};
    diff    = trial - {1'b0, dvsR};
    takeBit = ~diff[HALF_W];
  end

  // sign correction and range check
  logic [HALF_W-1:0] quoSigned, remSigned;
  logic              fitsWord, fitsByte, ovfNow;

  always_comb begin
    quoSigned = negQ ? -quoR : quoR;
    remSigned = negR ? -remR : remR;
    fitsWord  = ~quoR[HALF_W-1] | (negQ & (quoR[HALF_W-2:0] == '0));
    fitsByte  = ~quoR[BH-1]     | (negQ & (quoR[BH-2:0] == '0));
    ovfNow    = preOvf | ~(modeR ? fitsWord : fitsByte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remR     <= '0;
      quoR     <= '0;
      dvsR     <= '0;
      negQ     <= 1'b0;
      negR     <= 1'b0;
      preOvf   <= 1'b0;
      modeR    <= 1'b0;
      result   <= '0;
      divZero  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (strb.load) begin
        remR   <= remInit;
        quoR   <= quoInit;
        dvsR   <= dvsMag;
        negQ   <= dvdNeg ^ dvsNeg;
        negR   <= dvdNeg;
        preOvf <= (remInit >= dvsMag);
        modeR  <= wordMode;
      end
      if (strb.step) begin
        remR <= takeBit ? diff[HALF_W-1:0] : trial[HALF_W-1:0];
        quoR <= {quoR[HALF_W-2:0], takeBit};
      end
      if (strb.fix) begin
        divZero  <= 1'b0;
        overflow <= ovfNow;
        if (!ovfNow) begin
          if (modeR) result <= {remSigned, quoSigned};
          else       result <= {{HALF_W{1'b0}}, remSigned[BH-1:0], quoSigned[BH-1:0]};
        end
      end
      if (strb.zeroEnd) begin
        divZero  <= 1'b1;
        overflow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdiv_dual.sv
module sdiv_dual import sdiv_pkg::*; #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wordMode,
  input  logic [2*HALF_W-1:0] dividend,
  input  logic [HALF_W-1:0]   divisor,
  output logic                busy,
  output logic                done,
  output logic [2*HALF_W-1:0] result,
  output logic                divZero,
  output logic                overflow
);
  sdivStrobe_t strb;
  logic        dvsZero;

  sdiv_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wordMode (wordMode),
    .dvsZero  (dvsZero),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  sdiv_dpath #(.HALF_W(HALF_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wordMode (wordMode),
    .dividend (dividend),
    .divisor  (divisor),
    .dvsZero  (dvsZero),
    .result   (result),
    .divZero  (divZero),
    .overflow (overflow)
  );
endmodule

// File: rtl/sdiv_dual_chk.sv
module sdiv_dual_chk #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                wordMode,
  input logic [HALF_W-1:0]   divisor,
  input logic                busy,
  input logic                done,
  input logic [2*HALF_W-1:0] result,
  input logic                divZero,
  input logic                overflow
);
  localparam int BH = HALF_W / 2;
  logic zeroIn;
  assign zeroIn = wordMode ? (divisor == '0) : (divisor[BH-1:0] == '0);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !zeroIn) |=> (busy && !done));
  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && zeroIn) |=> (done && divZero && !overflow && !busy && $stable(result)));
  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow) |-> $stable(result));
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(divZero) && $stable(overflow)));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(divZero && overflow));
endmodule

bind sdiv_dual sdiv_dual_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wordMode(wordMode), .divisor(divisor),
  .busy(busy), .done(done), .result(result), .divZero(divZero), .overflow(overflow)
);

// File: tb/sdiv_dual_bench.sv
module sdiv_dual_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wordMode = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, divZero, overflow;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] expPrev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdiv_dual #(.HALF_W(HW)) u_sdiv_dual (
    .clk(clk), .rst_n(rst_n), .start(start), .wordMode(wordMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .result(result), .divZero(divZero), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic wm, input logic [31:0] dvd, input logic [15:0] dvs,
                                input logic [31:0] prev, output logic [31:0] res,
                                output logic dz, output logic ov, output int cyc);
    longint a, b, q, r, lim;
    int n;
    n   = wm ? 16 : 8;
    a   = wm ? longint'($signed(dvd)) : longint'($signed(dvd[15:0]));
    b   = wm ? longint'($signed(dvs)) : longint'($signed(dvs[7:0]));
    lim = longint'(1) <<< (n - 1);
    if (b == 0) begin
      dz = 1'b1; ov = 1'b0; res = prev; cyc = 0;
    end else begin
      q   = a / b;
      r   = a % b;
      dz  = 1'b0;
      ov  = (q > lim - 1) || (q < -lim);
      cyc = n + 1;
      if (ov)      res = prev;
      else if (wm) res = {r[15:0], q[15:0]};
      else         res = {16'h0, r[7:0], q[7:0]};
    end
  endfunction

  // runs one operation; when intrude is set, a second start with other operands
  // is pulsed while the first is busy (R6)
  task automatic runOp(input logic wm, input logic [31:0] dvd, input logic [15:0] dvs,
                       input string req, input bit intrude);
    logic [31:0] er; logic edz, eov; int ecyc; int cnt;
    model(wm, dvd, dvs, expPrev, er, edz, eov, ecyc);
    @(negedge clk);
    wordMode = wm; dividend = dvd; divisor = dvs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    if (ecyc > 0) check(busy === 1'b1, "R3", "busy after accept", 32'(busy), 32'd1);
    if (intrude && ecyc > 0) begin
      @(negedge clk); cnt++;
      @(negedge clk); cnt++;
      wordMode = ~wm; dividend = 32'h0000_0001; divisor = 16'h0003; start = 1'b1;
      @(negedge clk); cnt++;
      start = 1'b0;
    end
    while (!done && cnt < 64) begin
      @(negedge clk); cnt++;
    end
    check(cnt == ecyc, req, "cycles to done", 32'(cnt), 32'(ecyc));
    if (edz) check(busy === 1'b0, "R4", "busy on zero divisor", 32'(busy), 32'd0);
    check(result === er, req, "result", result, er);
    check(divZero === edz, req, "divZero", 32'(divZero), 32'(edz));
    check(overflow === eov, req, "overflow", 32'(overflow), 32'(eov));
    expPrev = er;
    @(negedge clk);
    check(done === 1'b0, "R3", "done one cycle", 32'(done), 32'd0);
    check(result === er && divZero === edz && overflow === eov, "R7", "hold after done", result, er);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    longint d, q, r, a, lim;
    int n;
    void'($urandom(32'd7319));
    repeat (3) @(negedge clk);
    // R8 reset state
    check(busy === 1'b0 && done === 1'b0, "R8", "busy/done in reset", {30'd0, busy, done}, 32'd0);
    check(result === 32'd0, "R8", "result in reset", result, 32'd0);
    check(divZero === 1'b0 && overflow === 1'b0, "R8", "flags in reset", {30'd0, divZero, overflow}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && result === 32'd0, "R8", "idle after reset", result, 32'd0);

    // R1 sign combinations, word mode
    runOp(1'b1, 32'd100, 16'd7, "R1", 0);
    runOp(1'b1, -32'sd100, 16'd7, "R1", 0);
    runOp(1'b1, 32'd100, -16'sd7, "R1", 0);
    runOp(1'b1, -32'sd100, -16'sd7, "R1", 0);
    runOp(1'b1, 32'd5, 16'd9, "R1", 0);
    // R2 byte mode with junk in upper input bits
    runOp(1'b0, 32'hDEAD_0064, 16'hAB07, "R2", 0);
    runOp(1'b0, 32'h1234_FF9C, 16'h55F9, "R2", 0);
    // R4 zero divisors
    runOp(1'b1, 32'd1234, 16'h0000, "R4", 0);
    runOp(1'b0, 32'h0000_0050, 16'h7700, "R4", 0);
    // R5 range edges
    runOp(1'b1, -32'sd32768, 16'd1, "R5", 0);
    runOp(1'b1, 32'd32768, -16'sd1, "R5", 0);
    runOp(1'b1, 32'd32768, 16'd1, "R5", 0);
    runOp(1'b1, 32'h8000_0000, 16'hFFFF, "R5", 0);
    runOp(1'b1, 32'h7FFF_FFFF, 16'h8000, "R5", 0);
    runOp(1'b0, 32'h0000_FF80, 16'h0001, "R5", 0);
    runOp(1'b0, 32'h0000_0080, 16'h0001, "R5", 0);
    runOp(1'b0, 32'h0000_8000, 16'h0080, "R5", 0);
    // R6 start while busy
    runOp(1'b1, 32'd70000, 16'd300, "R6", 1);
    runOp(1'b0, 32'hFFFF_F000, 16'h0025, "R6", 1);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic wm;
      logic [31:0] dvd;
      logic [15:0] dvs;
      wm  = 1'($urandom_range(0, 1));
      n   = wm ? 16 : 8;
      lim = longint'(1) <<< (n - 1);
      if ($urandom_range(0, 3) == 0) begin
        dvd = $urandom();
        dvs = 16'($urandom());
      end else begin
        d = longint'($urandom_range(1, 32'(lim))) * (($urandom_range(0, 1) == 1) ? -1 : 1);
        q = longint'($urandom_range(0, 32'(2 * lim))) - lim;
        r = longint'($urandom_range(0, 32'((d < 0 ? -d : d) - 1)));
        if (q * d < 0) r = -r;
        a = q * d + r;
        dvd = 32'(a);
        dvs = 16'(d);
      end
      runOp(wm, dvd, dvs, wm ? "R1" : "R2", (i % 17) == 5);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule